// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative store of recent virtual-page to physical-frame translations. Each lookup presents a 32-bit virtual address and an address-space identifier. One cycle later the block reports whether a stored translation matched. On a match it also returns the physical address: the stored frame number placed above the untouched 12-bit page offset. It returns the entry's protection bits and dirty bit as well. A miss is reported the same way with the hit flag low. The surrounding logic then obtains the translation elsewhere and installs it through the fill port.

Every entry records the identifier of the address space it belongs to. A lookup matches only when both the page number and the identifier agree, so translations of several processes can live side by side across context switches. Software-driven maintenance uses two inputs. One clears the whole array. The other clears only the entries of a single identifier. When a fill finds no free slot, a mode input selects the victim policy. Least-recently-used gives good locality. A pseudo-random choice avoids the pathological case where a loop cycles over one more page than there are entries.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, respValid is 0, and any lookup misses.
- R2: respValid is high exactly one cycle after lookupValid was high. respHit is 1 only when a valid entry's page number and identifier both equal the request's.
- R3: respPaddr bits [11:0] always equal the request's address bits [11:0]. On a hit, bits [31:12] hold the stored frame number. On a miss, bits [31:12], respProt and respDirty are 0.
- R4: A lookup whose identifier differs from the stored one misses, even when the page number matches.
- R5: Updates take effect before a lookup in the same cycle. A fill and a lookup of the same page and identifier in one cycle return a hit carrying the filled data.
- R6: A fill whose page number and identifier already match a valid entry rewrites that entry, so at most one entry ever matches a request.
- R7: A fill with no matching entry goes to the lowest-numbered invalid entry. The victim policy is used only when all entries are valid.
- R8: With replaceRandom=0 the victim is the entry touched longest ago. A fill touches its target entry. A lookup hit touches its entry only when no fill happens in the same cycle. At reset entry i counts as touched i steps ago, so entry 7 is the oldest.
- R9: With replaceRandom=1 the victim index is bits [2:0] of an 8-bit shift register. The register is set to 8'h01 by reset and moves every cycle to {q[6:0], q[7]^q[5]^q[4]^q[3]}; the victim is taken from its value before the fill's clock edge.
- R10: flushAll clears every entry's valid bit. A fill in the same cycle is applied after the clear and survives.
- R11: flushAsidValid clears exactly the valid entries whose identifier equals flushAsid and leaves all others usable. If flushAll is high in the same cycle, it already clears everything.
- R12: A hit returns the protection bits and dirty bit written by that entry's latest fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| replaceRandom | input | 1 | Victim policy: 0 least-recently-used, 1 pseudo-random |
| lookupValid | input | 1 | Lookup request strobe |
| lookupVaddr | input | 32 | Virtual address; [31:12] page number, [11:0] offset |
| lookupAsid | input | 8 | Address-space identifier of the lookup |
| fillValid | input | 1 | Install a translation this cycle |
| fillVpn | input | 20 | Page number being installed |
| fillAsid | input | 8 | Identifier being installed |
| fillPfn | input | 20 | Frame number being installed |
| fillProt | input | 3 | Protection bits being installed |
| fillDirty | input | 1 | Dirty bit being installed |
| flushAll | input | 1 | Invalidate every entry |
| flushAsidValid | input | 1 | Invalidate the entries of one identifier |
| flushAsid | input | 8 | Identifier cleared by flushAsidValid |
| respValid | output | 1 | Lookup result present |
| respHit | output | 1 | Lookup matched an entry |
| respPaddr | output | 32 | Physical address of the result |
| respProt | output | 3 | Protection bits of the matching entry |
| respDirty | output | 1 | Dirty bit of the matching entry |

## Verification
Some properties are checked on every clock. These are the one-cycle response timing, the pass-through of the page offset, the zeroed upper address bits on a miss, and the rule that no request ever matches two entries. Two state effects are also watched at every edge: a fill always leaves some entry valid, and a full clear without a fill empties the array. Victim choice under both policies, the same-cycle ordering of fill, clear and lookup, and the selective clear by identifier are shown only by the bench. It runs directed sequences and a seeded random mix, then compares every response with a behavioural model of the entry array, the touch order and the shift register.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int LFSR_W = 8;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 8'h01;

  typedef enum logic {
    REPL_LRU    = 1'b0,
    REPL_RANDOM = 1'b1
  } replMode_t;

  // strobes from control to the entry array
  typedef struct packed {
    logic clearAll;
    logic clearAsid;
    logic writeEn;
  } tlbStrobes_t;

endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int ASID_W = 8,
  parameter int OFF_W = 12,
  parameter int PROT_W = 3,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  tlbStrobes_t         strobe,
  input  logic [IDX_W-1:0]    writeIdx,
  input  logic [ASID_W-1:0]   flushAsid,
  input  logic [VPN_W-1:0]    fillVpn,
  input  logic [ASID_W-1:0]   fillAsid,
  input  logic [PFN_W-1:0]    fillPfn,
  input  logic [PROT_W-1:0]   fillProt,
  input  logic                fillDirty,
  input  logic                lookupValid,
  input  logic [VPN_W-1:0]    lookupVpn,
  input  logic [ASID_W-1:0]   lookupAsid,
  input  logic [OFF_W-1:0]    lookupOff,
  output logic [ENTRIES-1:0]  keptValid,
  output logic [ENTRIES-1:0]  fillKeyMatch,
  output logic [ENTRIES-1:0]  lookupMatch,
  output logic [ENTRIES-1:0]  validVec,
  output logic                respValid,
  output logic                respHit,
  output logic [PFN_W+OFF_W-1:0] respPaddr,
  output logic [PROT_W-1:0]   respProt,
  output logic                respDirty
);

  logic [ENTRIES-1:0] validQ;
  logic [VPN_W-1:0]   vpnQ   [ENTRIES];
  logic [ASID_W-1:0]  asidQ  [ENTRIES];
  logic [PFN_W-1:0]   pfnQ   [ENTRIES];
  logic [PROT_W-1:0]  protQ  [ENTRIES];
  logic [ENTRIES-1:0] dirtyQ;

  logic [ENTRIES-1:0] writeHit;
  logic [ENTRIES-1:0] nValid;
  logic [VPN_W-1:0]   nVpn   [ENTRIES];
  logic [ASID_W-1:0]  nAsid  [ENTRIES];
  logic [PFN_W-1:0]   nPfn   [ENTRIES];
  logic [PROT_W-1:0]  nProt  [ENTRIES];
  logic [ENTRIES-1:0] nDirty;

  assign validVec = validQ;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic asidCleared;
    assign asidCleared = strobe.clearAsid && (asidQ[i] == flushAsid);
    // clears come first, then the fill, then the lookup sees the result
    assign keptValid[i]    = validQ[i] && !strobe.clearAll && !asidCleared;
    assign fillKeyMatch[i] = keptValid[i] && (vpnQ[i] == fillVpn) && (asidQ[i] == fillAsid);
    assign writeHit[i]     = strobe.writeEn && (writeIdx == IDX_W'(i));
    assign nValid[i]       = writeHit[i] || keptValid[i];
    assign nVpn[i]         = writeHit[i] ? fillVpn   : vpnQ[i];
    assign nAsid[i]        = writeHit[i] ? fillAsid  : asidQ[i];
    assign nPfn[i]         = writeHit[i] ? fillPfn   : pfnQ[i];
    assign nProt[i]        = writeHit[i] ? fillProt  : protQ[i];
    assign nDirty[i]       = writeHit[i] ? fillDirty : dirtyQ[i];
    assign lookupMatch[i]  = lookupValid && nValid[i] &&
                             (nVpn[i] == lookupVpn) && (nAsid[i] == lookupAsid);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpnQ[i]  <= '0;
        asidQ[i] <= '0;
        pfnQ[i]  <= '0;
        protQ[i] <= '0;
      end
    end else begin
      validQ <= nValid;
      dirtyQ <= nDirty;
      for (int i = 0; i < ENTRIES; i++) begin
        vpnQ[i]  <= nVpn[i];
        asidQ[i] <= nAsid[i];
        pfnQ[i]  <= nPfn[i];
        protQ[i] <= nProt[i];
      end
    end
  end

  // at most one match, so an OR of gated fields selects the entry
  logic [PFN_W-1:0]  selPfn;
  logic [PROT_W-1:0] selProt;
  logic              selDirty;

  always_comb begin
    selPfn   = '0;
    selProt  = '0;
    selDirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookupMatch[i]) begin
        selPfn   = selPfn | nPfn[i];
        selProt  = selProt | nProt[i];
        selDirty = selDirty | nDirty[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respPaddr <= '0;
      respProt  <= '0;
      respDirty <= 1'b0;
    end else begin
      respValid <= lookupValid;
      respHit   <= |lookupMatch;
      respPaddr <= {selPfn, lookupOff};
      respProt  <= selProt;
      respDirty <= selDirty;
    end
  end

endmodule

// File: rtl/tlb_control.sv
module tlb_control
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               replaceRandom,
  input  logic               fillValid,
  input  logic               flushAll,
  input  logic               flushAsidValid,
  input  logic [ENTRIES-1:0] keptValid,
  input  logic [ENTRIES-1:0] fillKeyMatch,
  input  logic [ENTRIES-1:0] lookupMatch,
  output tlbStrobes_t        strobe,
  output logic [IDX_W-1:0]   writeIdx
);

  function automatic logic [IDX_W-1:0] lowestIdx(input logic [ENTRIES-1:0] v);
    lowestIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) lowestIdx = IDX_W'(i);
    end
  endfunction

  replMode_t mode;
  assign mode = replaceRandom ? REPL_RANDOM : REPL_LRU;

  // free-running pseudo-random source
  logic [LFSR_W-1:0] lfsrQ;
  logic              lfsrFb;
  assign lfsrFb = lfsrQ[7] ^ lfsrQ[5] ^ lfsrQ[4] ^ lfsrQ[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsrQ <= LFSR_SEED;
    else       lfsrQ <= {lfsrQ[LFSR_W-2:0], lfsrFb};
  end

  // recency ranks: 0 most recent, ENTRIES-1 oldest; always a permutation
  logic [IDX_W-1:0] ageQ [ENTRIES];
  logic [IDX_W-1:0] lruIdx;

  always_comb begin
    lruIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ageQ[i] == IDX_W'(ENTRIES - 1)) lruIdx = IDX_W'(i);
    end
  end

  logic [ENTRIES-1:0] freeVec;
  logic [IDX_W-1:0]   victimIdx;

  assign freeVec = ~keptValid;

  always_comb begin
    unique case (mode)
      REPL_RANDOM: victimIdx = lfsrQ[IDX_W-1:0];
      default:     victimIdx = lruIdx;
    endcase
    if (|fillKeyMatch)  writeIdx = lowestIdx(fillKeyMatch);
    else if (|freeVec)  writeIdx = lowestIdx(freeVec);
    else                writeIdx = victimIdx;
  end

  assign strobe.clearAll  = flushAll;
  assign strobe.clearAsid = flushAsidValid;
  assign strobe.writeEn   = fillValid;

  logic             touchEn;
  logic [IDX_W-1:0] touchIdx;

  assign touchEn  = fillValid || (|lookupMatch);
  assign touchIdx = fillValid ? writeIdx : lowestIdx(lookupMatch);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_age
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ageQ[i] <= IDX_W'(i);
      end else if (touchEn) begin
        if (touchIdx == IDX_W'(i))            ageQ[i] <= '0;
        else if (ageQ[i] < ageQ[touchIdx])    ageQ[i] <= ageQ[i] + 1'b1;
      end
    end
  end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int ASID_W = 8,
  parameter int OFF_W = 12,
  parameter int PROT_W = 3,
  localparam int VA_W = VPN_W + OFF_W,
  localparam int PA_W = PFN_W + OFF_W,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              replaceRandom,
  input  logic              lookupValid,
  input  logic [VA_W-1:0]   lookupVaddr,
  input  logic [ASID_W-1:0] lookupAsid,
  input  logic              fillValid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic [PFN_W-1:0]  fillPfn,
  input  logic [PROT_W-1:0] fillProt,
  input  logic              fillDirty,
  input  logic              flushAll,
  input  logic              flushAsidValid,
  input  logic [ASID_W-1:0] flushAsid,
  output logic              respValid,
  output logic              respHit,
  output logic [PA_W-1:0]   respPaddr,
  output logic [PROT_W-1:0] respProt,
  output logic              respDirty
);

  tlbStrobes_t        strobe;
  logic [IDX_W-1:0]   writeIdx;
  logic [ENTRIES-1:0] keptValid;
  logic [ENTRIES-1:0] fillKeyMatch;
  logic [ENTRIES-1:0] matchVec;
  logic [ENTRIES-1:0] validVec;

  tlb_control #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .replaceRandom (replaceRandom),
    .fillValid     (fillValid),
    .flushAll      (flushAll),
    .flushAsidValid(flushAsidValid),
    .keptValid     (keptValid),
    .fillKeyMatch  (fillKeyMatch),
    .lookupMatch   (matchVec),
    .strobe        (strobe),
    .writeIdx      (writeIdx)
  );

  tlb_datapath #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W),
    .ASID_W(ASID_W), .OFF_W(OFF_W), .PROT_W(PROT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .writeIdx    (writeIdx),
    .flushAsid   (flushAsid),
    .fillVpn     (fillVpn),
    .fillAsid    (fillAsid),
    .fillPfn     (fillPfn),
    .fillProt    (fillProt),
    .fillDirty   (fillDirty),
    .lookupValid (lookupValid),
    .lookupVpn   (lookupVaddr[VA_W-1:OFF_W]),
    .lookupAsid  (lookupAsid),
    .lookupOff   (lookupVaddr[OFF_W-1:0]),
    .keptValid   (keptValid),
    .fillKeyMatch(fillKeyMatch),
    .lookupMatch (matchVec),
    .validVec    (validVec),
    .respValid   (respValid),
    .respHit     (respHit),
    .respPaddr   (respPaddr),
    .respProt    (respProt),
    .respDirty   (respDirty)
  );

endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int ENTRIES = 8,
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int OFF_W = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               lookupValid,
  input logic [VA_W-1:0]    lookupVaddr,
  input logic               fillValid,
  input logic               flushAll,
  input logic               respValid,
  input logic               respHit,
  input logic [PA_W-1:0]    respPaddr,
  input logic [ENTRIES-1:0] matchVec,
  input logic [ENTRIES-1:0] validVec
);

  // R2
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);

  // R2
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !respValid);

  // R2
  hit_needs_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> respValid);

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respPaddr[OFF_W-1:0] == $past(lookupVaddr[OFF_W-1:0]));

  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> respPaddr[PA_W-1:OFF_W] == '0);

  // R6
  single_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flushAll && !fillValid) |=> validVec == '0);

  // R5
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |=> validVec != '0);

endmodule

bind asid_tlb asid_tlb_chk #(
  .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)
) chk (
  .clk        (clk),
  .rstN       (rstN),
  .lookupValid(lookupValid),
  .lookupVaddr(lookupVaddr),
  .fillValid  (fillValid),
  .flushAll   (flushAll),
  .respValid  (respValid),
  .respHit    (respHit),
  .respPaddr  (respPaddr),
  .matchVec   (matchVec),
  .validVec   (validVec)
);

// File: tb/asid_tlb_test.sv
`timescale 1ns/1ps
module asid_tlb_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pRnd = 1'b0, pLv = 1'b0, pFv = 1'b0, pFa = 1'b0, pFav = 1'b0, pFd = 1'b0;
  logic [31:0] pVa = '0;
  logic [7:0]  pLa = '0, pFasid = '0, pFas = '0;
  logic [19:0] pFvpn = '0, pFpfn = '0;
  logic [2:0]  pFprot = '0;
  logic        respValid, respHit, respDirty;
  logic [31:0] respPaddr;
  logic [2:0]  respProt;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  asid_tlb uut (
    .clk(clk), .rstN(rstN), .replaceRandom(pRnd),
    .lookupValid(pLv), .lookupVaddr(pVa), .lookupAsid(pLa),
    .fillValid(pFv), .fillVpn(pFvpn), .fillAsid(pFasid), .fillPfn(pFpfn),
    .fillProt(pFprot), .fillDirty(pFd),
    .flushAll(pFa), .flushAsidValid(pFav), .flushAsid(pFas),
    .respValid(respValid), .respHit(respHit), .respPaddr(respPaddr),
    .respProt(respProt), .respDirty(respDirty)
  );

  // behavioural model
  logic        mV [8];
  logic [19:0] mVpn [8];
  logic [7:0]  mAsid [8];
  logic [19:0] mPfn [8];
  logic [2:0]  mProt [8];
  logic        mDirty [8];
  int          mAge [8];
  logic [7:0]  mLfsr;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) mLfsr <= 8'h01;
    else       mLfsr <= {mLfsr[6:0], mLfsr[7] ^ mLfsr[5] ^ mLfsr[4] ^ mLfsr[3]};
  end

  function automatic void modelReset();
    for (int i = 0; i < 8; i++) begin
      mV[i] = 1'b0;
      mAge[i] = i;
    end
  endfunction

  function automatic void touch(int t);
    int a = mAge[t];
    for (int i = 0; i < 8; i++) begin
      if (i == t) mAge[i] = 0;
      else if (mAge[i] < a) mAge[i]++;
    end
  endfunction

  function automatic int pickSlot();
    int w = -1;
    for (int i = 0; i < 8; i++)
      if (mV[i] && mVpn[i] == pFvpn && mAsid[i] == pFasid) w = i;
    if (w < 0)
      for (int i = 7; i >= 0; i--) if (!mV[i]) w = i;
    if (w < 0) begin
      if (pRnd) w = int'(mLfsr[2:0]);
      else for (int i = 0; i < 8; i++) if (mAge[i] == 7) w = i;
    end
    return w;
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic clearPend();
    pLv = 1'b0; pFv = 1'b0; pFa = 1'b0; pFav = 1'b0;
  endtask

  // one cycle: drive at negedge, update model, sample after the edge
  task automatic step(input string tag);
    int w;
    int hit;
    logic [31:0] expPa;
    logic [2:0]  expProt;
    logic        expDirty;
    @(negedge clk);
    if (pFa) begin
      for (int i = 0; i < 8; i++) mV[i] = 1'b0;
    end else if (pFav) begin
      for (int i = 0; i < 8; i++) if (mV[i] && mAsid[i] == pFas) mV[i] = 1'b0;
    end
    if (pFv) begin
      w = pickSlot();
      mV[w] = 1'b1; mVpn[w] = pFvpn; mAsid[w] = pFasid;
      mPfn[w] = pFpfn; mProt[w] = pFprot; mDirty[w] = pFd;
      touch(w);
    end
    hit = -1;
    if (pLv)
      for (int i = 0; i < 8; i++)
        if (mV[i] && mVpn[i] == pVa[31:12] && mAsid[i] == pLa) hit = i;
    if (hit >= 0 && !pFv) touch(hit);
    expPa = {20'h0, pVa[11:0]};
    expProt = '0;
    expDirty = 1'b0;
    if (hit >= 0) begin
      expPa[31:12] = mPfn[hit];
      expProt = mProt[hit];
      expDirty = mDirty[hit];
    end
    @(posedge clk);
    #1;
    check(respValid === pLv, "R2", "respValid", {31'h0, respValid}, {31'h0, pLv});
    if (pLv) begin
      check(respHit === (hit >= 0), tag, "respHit", {31'h0, respHit}, {31'h0, hit >= 0});
      check(respPaddr === expPa, tag, "respPaddr", respPaddr, expPa);
      check(respProt === expProt && respDirty === expDirty, tag, "prot/dirty",
            {28'h0, respProt, respDirty}, {28'h0, expProt, expDirty});
    end
    clearPend();
  endtask

  task automatic lookup(input logic [19:0] vpn, input logic [7:0] asid, input string tag);
    pLv = 1'b1; pVa = {vpn, 12'($urandom)}; pLa = asid;
    step(tag);
  endtask

  task automatic setFill(input logic [19:0] vpn, input logic [7:0] asid,
                         input logic [19:0] pfn, input logic [2:0] prot, input logic d);
    pFv = 1'b1; pFvpn = vpn; pFasid = asid; pFpfn = pfn; pFprot = prot; pFd = d;
  endtask

  initial begin
    #(4 * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5eed);
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    check(respValid === 1'b0, "R1", "respValid in reset", {31'h0, respValid}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    // R1: empty after reset
    lookup(20'h00000, 8'h00, "R1");
    lookup(20'hABCDE, 8'h12, "R1");

    // R7 R12 R3: fill all eight entries, then read them back
    for (int i = 0; i < 8; i++) begin
      setFill(20'h100 + 20'(i), 8'h05, 20'h8000 + 20'(i * 3), 3'(i), i[0]);
      step("R7");
    end
    for (int i = 0; i < 8; i++) lookup(20'h100 + 20'(i), 8'h05, "R12");
    // R4: same page, other identifier
    lookup(20'h103, 8'h06, "R4");
    // R8: touch entry 0, the new fill must evict the next oldest
    lookup(20'h100, 8'h05, "R8");
    setFill(20'h200, 8'h05, 20'hFEDCB, 3'h7, 1'b1);
    step("R8");
    lookup(20'h101, 8'h05, "R8");
    lookup(20'h100, 8'h05, "R8");
    lookup(20'h200, 8'h05, "R8");
    // R6: refill of an existing key rewrites in place
    setFill(20'h104, 8'h05, 20'h12345, 3'h2, 1'b0);
    step("R6");
    lookup(20'h104, 8'h05, "R6");
    lookup(20'h105, 8'h05, "R6");
    // R5: fill and lookup in the same cycle
    setFill(20'h300, 8'h09, 20'h0BEEF, 3'h5, 1'b1);
    pLv = 1'b1; pVa = {20'h300, 12'hA5C}; pLa = 8'h09;
    step("R5");
    // R9: random victim
    pRnd = 1'b1;
    setFill(20'h400, 8'h09, 20'h44444, 3'h1, 1'b0);
    step("R9");
    setFill(20'h401, 8'h09, 20'h44445, 3'h1, 1'b0);
    step("R9");
    for (int i = 0; i < 8; i++) lookup(20'h100 + 20'(i), 8'h05, "R9");
    pRnd = 1'b0;
    // R11: clear identifier 9 only
    pFav = 1'b1; pFas = 8'h09;
    step("R11");
    lookup(20'h400, 8'h09, "R11");
    lookup(20'h300, 8'h09, "R11");
    lookup(20'h102, 8'h05, "R11");
    lookup(20'h200, 8'h05, "R11");
    // R7: freed slots are reused before any eviction
    setFill(20'h500, 8'h01, 20'h55555, 3'h3, 1'b1);
    step("R7");
    lookup(20'h500, 8'h01, "R7");
    // R10: full clear, and clear plus fill in one cycle
    pFa = 1'b1;
    step("R10");
    lookup(20'h500, 8'h01, "R10");
    lookup(20'h106, 8'h05, "R10");
    pFa = 1'b1;
    setFill(20'h600, 8'h02, 20'h66666, 3'h6, 1'b0);
    step("R10");
    lookup(20'h600, 8'h02, "R10");

    // random mix over a small key pool so hits, refills and evictions occur
    for (int n = 0; n < 600; n++) begin
      pRnd = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 9) < 7) begin
        pLv = 1'b1;
        pVa = {20'($urandom_range(0, 11)), 12'($urandom)};
        pLa = 8'($urandom_range(0, 2));
      end
      if ($urandom_range(0, 9) < 4)
        setFill(20'($urandom_range(0, 11)), 8'($urandom_range(0, 2)),
                20'($urandom), 3'($urandom), 1'($urandom));
      if ($urandom_range(0, 99) < 5) begin
        pFav = 1'b1;
        pFas = 8'($urandom_range(0, 2));
      end
      if ($urandom_range(0, 99) < 2) pFa = 1'b1;
      step(pFv ? "R8" : "R2");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule